// File: doc/BRIEF.md
# PHY Extender-Sublayer Management Register Set

This block holds the control, status and fault-summary registers of a 10 Gb/s PHY extender-sublayer management device. A host reaches it through a plain register port: a 16-bit register offset, a 16-bit write word, and single-cycle read and write strobes. Read data is combinational from the offset, so it is valid in the same cycle as the read strobe. Any read side effect takes hold at the next rising clock edge.

Raw hardware status enters on separate pins. These are a transmit link-good level, a transmit fault level, a receive fault level, and a strobe that marks a read of an external alarm-status register. The block turns these into sticky status bits. The link-good bit latches low. The two fault bits latch high. Reading a register restores its sticky bits, and the alarm strobe also clears the fault bits. A self-clearing reset bit drives a chip reset pulse of fixed length. During that pulse every register is held at its default value.

Top module: `phyxs_mgmt_regs`

## Requirements
- R1: Writing offset 0 with bit 15 set, when no reset is in progress, raises `chip_rst_pulse` for exactly 16 cycles starting at the next clock. Offset 0 bit 15 reads 1 during those cycles and 0 afterwards. When the pulse ends, loopback, link and fault bits hold their default values.
- R2: Offset 0 bit 14 is a read/write loopback enable that drives `loopback_en`. It resets to 0. A write with bit 15 set forces it to 0.
- R3: In offset 0, bits 13 and 6 always read 1. Bits 12, 11, 10:7, 5:2 and 1:0 always read 0. Writes to these bits, including the low-power bit 11, have no effect.
- R4: Offset 1 bit 2 (transmit link up) resets to 1. It becomes 0 in the cycle after `tx_link_ok` is low. It returns to 1 after a read of offset 1, but only if `tx_link_ok` is high in the read cycle.
- R5: Offset 1 bit 1 (low-power ability) reads 0. Offset 1 bit 7 reads as the OR of offset 8 bits 11 and 10. All other offset 1 bits read 0.
- R6: Offset 8 bits 15:14 always read binary 10 (device present).
- R7: Offset 8 bit 11 latches 1 in the cycle after `tx_fault` is high. Offset 8 bit 10 does the same for `rx_fault`. A read of offset 8 returns the latched values and then clears them to 0.
- R8: A high `alarm_rd_strobe` clears offset 8 bits 11 and 10, exactly as a read of offset 8 does.
- R9: If a fault input is high in the same cycle as a clear (an offset 8 read or the alarm strobe), its bit stays 1.
- R10: Reads of any offset other than 0, 1 and 8 return 0. Writes to offsets 1 and 8, or to other offsets, change nothing.
- R11: While `chip_rst_pulse` is high, writes are ignored and fault or link events are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tx_link_ok | input | 1 | Transmit link good (signal, byte sync, lane alignment) |
| tx_fault | input | 1 | Transmit-side fault level |
| rx_fault | input | 1 | Receive-side fault level |
| alarm_rd_strobe | input | 1 | Read of external alarm-status register |
| chip_rst_pulse | output | 1 | Device reset pulse |
| loopback_en | output | 1 | Loopback on all lanes |

## Verification
The assertions assume these conditions on the inputs:
- Every input is synchronous to the clock and free of unknown values.
- A read or write lasts one cycle per strobe.
- Fault and link levels may change on any cycle.

The stimulus changes inputs only on the falling edge. It holds reset for the first cycles. It then mixes directed sequences with random traffic, and that traffic includes the following events:
- fault and link events that coincide with reads and alarm strobes;
- writes and reads during the reset pulse;
- accesses to unused offsets.

// File: rtl/phyxs_mgmt_pkg.sv
package phyxs_mgmt_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 16'd0;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 16'd1;
    localparam logic [ADDR_W-1:0] OFF_FAULTS = 16'd8;

    localparam int BIT_RESET    = 15;
    localparam int BIT_LOOPBACK = 14;
    localparam int BIT_SPD_HI   = 13;
    localparam int BIT_SPD_LO   = 6;
    localparam int BIT_FLT_SUM  = 7;
    localparam int BIT_LINK     = 2;
    localparam int BIT_TX_FLT   = 11;
    localparam int BIT_RX_FLT   = 10;

    typedef struct packed {
        logic link_up;
        logic tx_flt;
        logic rx_flt;
    } sticky_t;

    localparam sticky_t STICKY_DEFAULT = '{link_up: 1'b1, tx_flt: 1'b0, rx_flt: 1'b0};

    function automatic logic [DATA_W-1:0] ctrl_word(input logic busy, input logic lb);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_RESET]    = busy;
        w[BIT_LOOPBACK] = lb;
        w[BIT_SPD_HI]   = 1'b1;
        w[BIT_SPD_LO]   = 1'b1;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input sticky_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_FLT_SUM] = s.tx_flt | s.rx_flt;
        w[BIT_LINK]    = s.link_up;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] fault_word(input sticky_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[15:14]      = 2'b10;
        w[BIT_TX_FLT] = s.tx_flt;
        w[BIT_RX_FLT] = s.rx_flt;
        return w;
    endfunction

endpackage

// File: rtl/phyxs_reset_ctrl.sv
module phyxs_reset_ctrl
    import phyxs_mgmt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              loopback
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             lb_q;

    assign busy     = (cnt_q != '0);
    assign loopback = lb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lb_q  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
            lb_q  <= 1'b0;
        end else if (ctrl_wr) begin
            if (wdata[BIT_RESET]) begin
                cnt_q <= CNT_W'(RST_CYCLES);
                lb_q  <= 1'b0;
            end else begin
                lb_q  <= wdata[BIT_LOOPBACK];
            end
        end
    end

    assert_busy_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q > 1) |=> busy);
    assert_busy_end_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cnt_q) == 1);
    assert_start_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctrl_wr && wdata[BIT_RESET]));
    assert_lb_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> !lb_q);

endmodule

// File: rtl/phyxs_sticky_bits.sv
module phyxs_sticky_bits
    import phyxs_mgmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold_default,
    input  logic    tx_link_ok,
    input  logic    tx_fault,
    input  logic    rx_fault,
    input  logic    stat_read,
    input  logic    fault_clear,
    output sticky_t sticky
);
    sticky_t s_q;

    assign sticky = s_q;

    always_ff @(posedge clk) begin
        if (rst || hold_default) begin
            s_q <= STICKY_DEFAULT;
        end else begin
            if (!tx_link_ok)    s_q.link_up <= 1'b0;
            else if (stat_read) s_q.link_up <= 1'b1;

            if (tx_fault)         s_q.tx_flt <= 1'b1;
            else if (fault_clear) s_q.tx_flt <= 1'b0;

            if (rx_fault)         s_q.rx_flt <= 1'b1;
            else if (fault_clear) s_q.rx_flt <= 1'b0;
        end
    end

    assert_link_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!tx_link_ok && !hold_default) |=> !s_q.link_up);
    assert_tx_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_fault && !hold_default) |=> s_q.tx_flt);
    assert_rx_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_fault && !hold_default) |=> s_q.rx_flt);
    assert_clear_race_R9: assert property (@(posedge clk) disable iff (rst)
        (fault_clear && tx_fault && !hold_default) |=> s_q.tx_flt);
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (fault_clear && !tx_fault && !rx_fault) |=> (!s_q.tx_flt && !s_q.rx_flt));

endmodule

// File: rtl/phyxs_read_mux.sv
module phyxs_read_mux
    import phyxs_mgmt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic              loopback,
    input  sticky_t           sticky,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (addr)
            OFF_CTRL:   rdata = ctrl_word(busy, loopback);
            OFF_STAT:   rdata = stat_word(sticky);
            OFF_FAULTS: rdata = fault_word(sticky);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/phyxs_mgmt_regs.sv
module phyxs_mgmt_regs
    import phyxs_mgmt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_link_ok,
    input  logic              tx_fault,
    input  logic              rx_fault,
    input  logic              alarm_rd_strobe,
    output logic              chip_rst_pulse,
    output logic              loopback_en
);
    logic    busy;
    logic    lb;
    sticky_t sticky;
    logic    ctrl_wr;
    logic    stat_read;
    logic    fault_clear;

    assign ctrl_wr     = reg_wr && (reg_addr == OFF_CTRL);
    assign stat_read   = reg_rd && (reg_addr == OFF_STAT);
    assign fault_clear = (reg_rd && (reg_addr == OFF_FAULTS)) || alarm_rd_strobe;

    phyxs_reset_ctrl #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wdata    (reg_wdata),
        .busy     (busy),
        .loopback (lb)
    );

    phyxs_sticky_bits u_sticky (
        .clk          (clk),
        .rst          (rst),
        .hold_default (busy),
        .tx_link_ok   (tx_link_ok),
        .tx_fault     (tx_fault),
        .rx_fault     (rx_fault),
        .stat_read    (stat_read),
        .fault_clear  (fault_clear),
        .sticky       (sticky)
    );

    phyxs_read_mux u_mux (
        .addr     (reg_addr),
        .busy     (busy),
        .loopback (lb),
        .sticky   (sticky),
        .rdata    (reg_rdata)
    );

    assign chip_rst_pulse = busy;
    assign loopback_en    = lb;

    assert_present_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_FAULTS) |-> reg_rdata[15:14] == 2'b10);
    assert_fixed_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_CTRL) |-> (reg_rdata[13] && reg_rdata[6] && !reg_rdata[11]
                                    && reg_rdata[5:2] == 4'b0000));
    assert_summary_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_STAT) |-> (reg_rdata[7] == (sticky.tx_flt | sticky.rx_flt)) && !reg_rdata[1]);
    assert_bit15_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_CTRL) |-> reg_rdata[15] == chip_rst_pulse);

endmodule

// File: tb/phyxs_mgmt_regs_tb.sv
module phyxs_mgmt_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic        tx_link_ok = 1'b1;
    logic        tx_fault = 1'b0;
    logic        rx_fault = 1'b0;
    logic        alarm_rd_strobe = 1'b0;
    logic        chip_rst_pulse;
    logic        loopback_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    phyxs_mgmt_regs dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .tx_link_ok(tx_link_ok), .tx_fault(tx_fault), .rx_fault(rx_fault),
        .alarm_rd_strobe(alarm_rd_strobe), .chip_rst_pulse(chip_rst_pulse),
        .loopback_en(loopback_en)
    );

    // Behavioural reference state
    int m_left = 0;
    bit m_lb = 0;
    bit m_link = 1;
    bit m_txf = 0;
    bit m_rxf = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_left = 0; m_lb = 0; m_link = 1; m_txf = 0; m_rxf = 0;
        end else if (m_left > 0) begin
            // R11: everything held at default, writes and events ignored
            m_left = m_left - 1;
            m_lb = 0; m_link = 1; m_txf = 0; m_rxf = 0;
        end else begin
            if (reg_wr && reg_addr == 16'd0) begin
                if (reg_wdata[15]) begin m_left = 16; m_lb = 0; end
                else m_lb = reg_wdata[14];
            end
            if (!tx_link_ok) m_link = 0;
            else if (reg_rd && reg_addr == 16'd1) m_link = 1;
            if (tx_fault) m_txf = 1;
            else if ((reg_rd && reg_addr == 16'd8) || alarm_rd_strobe) m_txf = 0;
            if (rx_fault) m_rxf = 1;
            else if ((reg_rd && reg_addr == 16'd8) || alarm_rd_strobe) m_rxf = 0;
        end
    end

    function automatic logic [15:0] exp_rdata(input logic [15:0] a);
        logic [15:0] w = '0;
        if (a == 16'd0) begin
            w[15] = (m_left > 0); w[14] = m_lb; w[13] = 1; w[6] = 1;
        end else if (a == 16'd1) begin
            w[7] = m_txf | m_rxf; w[2] = m_link;
        end else if (a == 16'd8) begin
            w[15:14] = 2'b10; w[11] = m_txf; w[10] = m_rxf;
        end
        return w;
    endfunction

    function automatic string req_of(input logic [15:0] a);
        if (a == 16'd0) return "R1/R2/R3/R11";
        if (a == 16'd1) return "R4/R5";
        if (a == 16'd8) return "R6/R7/R8/R9";
        return "R10";
    endfunction

    // Compare every cycle, 2 ns before the rising edge
    always @(negedge clk) begin
        #8;
        if (!rst && !done) begin
            logic [15:0] e;
            e = exp_rdata(reg_addr);
            n_cmp++;
            if (reg_rdata !== e) begin
                n_bad++;
                $display("FAIL %s addr=%0d rdata actual=%h expected=%h", req_of(reg_addr), reg_addr, reg_rdata, e);
            end
            n_cmp++;
            if (chip_rst_pulse !== (m_left > 0)) begin
                n_bad++;
                $display("FAIL R1 chip_rst_pulse actual=%b expected=%b", chip_rst_pulse, (m_left > 0));
            end
            n_cmp++;
            if (loopback_en !== m_lb) begin
                n_bad++;
                $display("FAIL R2 loopback_en actual=%b expected=%b", loopback_en, m_lb);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            reg_wr = 0; reg_rd = 0; alarm_rd_strobe = 0;
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1; reg_rd = 0; alarm_rd_strobe = 0;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        reg_addr = a; reg_rd = 1; reg_wr = 0; alarm_rd_strobe = 0;
        @(negedge clk);
        reg_rd = 0;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst = 0;
        // Reset state, R3 fixed bits, R10 unused offsets
        rd(16'd0); rd(16'd1); rd(16'd8); rd(16'd5); rd(16'hFFFF);
        // R2 loopback, R3 writes to fixed bits ignored
        wr(16'd0, 16'h7FFF); rd(16'd0);
        wr(16'd0, 16'h0000); rd(16'd0);
        wr(16'd0, 16'h4800); rd(16'd0);
        // R10 writes to read-only offsets ignored
        wr(16'd8, 16'h0000); wr(16'd1, 16'hFFFF); wr(16'd3, 16'hFFFF); rd(16'd8); rd(16'd3);
        // R4 link latch low, read restores
        @(negedge clk); tx_link_ok = 0; idle(2);
        @(negedge clk); tx_link_ok = 1;
        rd(16'd1); rd(16'd1);
        // R4 read while link bad keeps it low
        @(negedge clk); tx_link_ok = 0; rd(16'd1); @(negedge clk); tx_link_ok = 1; rd(16'd1); rd(16'd1);
        // R7 fault latch and clear-on-read, R5 summary
        @(negedge clk); tx_fault = 1; @(negedge clk); tx_fault = 0;
        rd(16'd1); rd(16'd8); rd(16'd8);
        @(negedge clk); rx_fault = 1; @(negedge clk); rx_fault = 0;
        rd(16'd1);
        // R8 alarm strobe clears
        @(negedge clk); alarm_rd_strobe = 1; @(negedge clk); alarm_rd_strobe = 0;
        rd(16'd8);
        // R9 fault coincident with clear stays latched
        @(negedge clk); tx_fault = 1; reg_addr = 16'd8; reg_rd = 1;
        @(negedge clk); tx_fault = 0; reg_rd = 0; rd(16'd8);
        @(negedge clk); rx_fault = 1; alarm_rd_strobe = 1;
        @(negedge clk); rx_fault = 0; alarm_rd_strobe = 0; rd(16'd8); rd(16'd8);
        // R1 self-clearing reset; R11 writes and events ignored during it
        wr(16'd0, 16'h4000);
        @(negedge clk); tx_fault = 1; @(negedge clk); tx_fault = 0;
        wr(16'd0, 16'hC000);
        wr(16'd0, 16'h4000);
        @(negedge clk); rx_fault = 1; tx_link_ok = 0; reg_addr = 16'd0;
        @(negedge clk); rx_fault = 0; tx_link_ok = 1;
        idle(20); rd(16'd0); rd(16'd1); rd(16'd8);
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            case ($urandom_range(0, 3))
                0: reg_addr = 16'd0;
                1: reg_addr = 16'd1;
                2: reg_addr = 16'd8;
                default: reg_addr = 16'($urandom_range(2, 40));
            endcase
            reg_wdata = 16'($urandom);
            if ($urandom_range(0, 15) != 0) reg_wdata[15] = 0;
            reg_wr = ($urandom_range(0, 3) == 0);
            reg_rd = !reg_wr && ($urandom_range(0, 1) == 0);
            tx_link_ok = ($urandom_range(0, 7) != 0);
            tx_fault = ($urandom_range(0, 7) == 0);
            rx_fault = ($urandom_range(0, 7) == 0);
            alarm_rd_strobe = ($urandom_range(0, 9) == 0);
        end
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule